// File: doc/BRIEF.md
# Flash Access Disable Gate

This block sits between the requesters of a flash subsystem and the flash physical interface. It gathers four independent disable causes into one sticky disabled state and then applies that state in layers. Requests from the host bus adapter and from the protocol controller stop being forwarded and are each answered with a single error beat. At the physical interface, a program or erase that is already running is allowed to finish. Any read caught mid-flight is abandoned with an error. Every later physical transaction is silently discarded.

Each path is a request/response pass-through. While the gate is enabled it adds no latency and alters nothing. Each requester is assumed to keep at most one transaction outstanding and to issue a new request only after the previous response. The physical path carries an operation code with 2'd0 = read, 2'd1 = program and 2'd2 = erase. Only reset clears the disabled state.

Top module: `flash_access_gate`

## Requirements
- R1: The disable causes map to status bits as follows: bit 0 is the global escalation, bit 1 the local escalation, bit 2 the end of the return-to-manufacturer wipe, and bit 3 the software disable. A cause sampled high at a clock edge sets its bit in `dis_src_o`. From the next cycle onward `disabled_o` is high and every path behaves as disabled.
- R2: Once set, status bits and `disabled_o` stay high after the causes drop, until a reset cycle clears them.
- R3: While enabled, a host request is forwarded in the same cycle with its address unchanged. The downstream response is returned in the same cycle with its data and the error flag low.
- R4: While disabled, a host request is not forwarded. Exactly one response beat follows in the next cycle, with the error flag high and data zero.
- R5: While enabled, a controller request (operation and address) is forwarded in the same cycle. Its downstream response is returned in the same cycle with the error flag low.
- R6: While disabled, a controller request is not forwarded. Exactly one error beat with zero data follows in the next cycle.
- R7: While enabled and idle, a physical request is forwarded in the same cycle. The physical completion is returned as a response in the same cycle, carrying the read data and the error flag low.
- R8: While disabled, physical requests are never forwarded and produce no response. Completions that arrive with nothing outstanding produce no response.
- R9: A program or erase still outstanding when the disabled state takes effect completes normally. Its completion is returned with the error flag low.
- R10: A read still outstanding when the disabled state takes effect gets an error response with zero data in the first disabled cycle. Its later completion is swallowed.
- R11: During and right after reset, all status bits are zero and no request is forwarded or answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| esc_global_i | input | 1 | Global escalation cause |
| esc_local_i | input | 1 | Local escalation cause |
| rma_done_i | input | 1 | Return-to-manufacturer wipe finished |
| sw_disable_i | input | 1 | Software disable command |
| dis_src_o | output | 4 | Sticky per-cause status |
| disabled_o | output | 1 | Gate is disabled |
| host_req_i | input | 1 | Host read request |
| host_addr_i | input | AW | Host address |
| host_fwd_req_o | output | 1 | Forwarded host request |
| host_fwd_addr_o | output | AW | Forwarded host address |
| host_fwd_rsp_i | input | 1 | Downstream host response |
| host_fwd_rdata_i | input | DW | Downstream host data |
| host_rsp_o | output | 1 | Host response beat |
| host_rsp_err_o | output | 1 | Host response error |
| host_rdata_o | output | DW | Host response data |
| ctrl_req_i | input | 1 | Controller request |
| ctrl_op_i | input | 2 | Controller operation |
| ctrl_addr_i | input | AW | Controller address |
| ctrl_fwd_req_o | output | 1 | Forwarded controller request |
| ctrl_fwd_op_o | output | 2 | Forwarded controller operation |
| ctrl_fwd_addr_o | output | AW | Forwarded controller address |
| ctrl_fwd_rsp_i | input | 1 | Downstream controller response |
| ctrl_fwd_rdata_i | input | DW | Downstream controller data |
| ctrl_rsp_o | output | 1 | Controller response beat |
| ctrl_rsp_err_o | output | 1 | Controller response error |
| ctrl_rdata_o | output | DW | Controller response data |
| phy_req_i | input | 1 | Physical request |
| phy_op_i | input | 2 | Physical operation (0 read, 1 program, 2 erase) |
| phy_addr_i | input | AW | Physical address |
| phy_fwd_req_o | output | 1 | Request issued to the flash macro |
| phy_fwd_op_o | output | 2 | Operation issued to the macro |
| phy_fwd_addr_o | output | AW | Address issued to the macro |
| phy_done_i | input | 1 | Macro completion |
| phy_rdata_i | input | DW | Macro read data |
| phy_rsp_o | output | 1 | Physical response beat |
| phy_rsp_err_o | output | 1 | Physical response error |
| phy_rdata_o | output | DW | Physical response data |

## Verification
The hardest situation to reach from the ports is a disable cause that arrives while a physical transaction is outstanding. The outcome then depends on the kind of operation that is in flight. The stimulus issues a read, a program or an erase, holds back the macro completion, and pulses a different cause in each case. It then delivers the completion late, which shows either that the completion passes through untouched or that it is swallowed after the early error beat.

// File: rtl/fad_pkg.sv
// Shared constants for the flash access disable gate.
// Assumes nothing beyond a 2-bit physical operation code.
package fad_pkg;
    localparam int NSRC     = 4;
    localparam int SRC_GLB  = 0;
    localparam int SRC_LOC  = 1;
    localparam int SRC_WIPE = 2;
    localparam int SRC_SW   = 3;
    localparam int OPW      = 2;
    localparam logic [OPW-1:0] OP_READ  = 2'd0;
    localparam logic [OPW-1:0] OP_PROG  = 2'd1;
    localparam logic [OPW-1:0] OP_ERASE = 2'd2;
endpackage

// File: rtl/fad_src_latch.sv
// Sticky capture of the disable causes.
// Each cause bit is latched at the clock edge where it is seen high and
// only reset clears it. The disable flag is the OR of the latched bits.
module fad_src_latch #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src_i,
    output logic [N-1:0] seen_o,
    output logic         dis_o
);
    logic [N-1:0] seen_q;

    // accumulate causes; reset is the only way out
    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= '0;
        else        seen_q <= seen_q | src_i;
    end

    assign seen_o = seen_q;
    assign dis_o  = |seen_q;

    for (genvar i = 0; i < N; i++) begin : g_chk
        a_r1_capture: assert property (@(posedge clk) disable iff (!rst_n)
            src_i[i] |=> seen_q[i]);
        a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            seen_q[i] |=> seen_q[i]);
    end
endmodule

// File: rtl/fad_req_gate.sv
// Request/response gate for one requester path (host or controller).
// Enabled: request and response pass through combinationally.
// Disabled: the request is held back and one error beat is sent the
// following cycle. Assumes one outstanding transaction per requester.
module fad_req_gate #(
    parameter int PW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dis_i,
    input  logic          req_vld_i,
    input  logic [PW-1:0] req_pld_i,
    output logic          fwd_vld_o,
    output logic [PW-1:0] fwd_pld_o,
    input  logic          fwd_rsp_vld_i,
    input  logic [DW-1:0] fwd_rsp_data_i,
    output logic          rsp_vld_o,
    output logic          rsp_err_o,
    output logic [DW-1:0] rsp_data_o
);
    logic err_q;

    // remember a refused request so that its error beat goes out next cycle
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= dis_i & req_vld_i;
    end

    // forwarding path
    always_comb begin
        fwd_vld_o = req_vld_i & ~dis_i;
        fwd_pld_o = req_pld_i;
    end

    // merge of the error beat and the downstream response
    always_comb begin
        rsp_vld_o  = err_q | fwd_rsp_vld_i;
        rsp_err_o  = err_q;
        rsp_data_o = err_q ? '0 : fwd_rsp_data_i;
    end

    // R3 / R5: an enabled request passes unchanged
    a_r3_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (!dis_i && req_vld_i) |-> (fwd_vld_o && fwd_pld_o == req_pld_i));
    // R4 / R6: a refused request gets one error beat
    a_r4_err_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_i && req_vld_i) |=> (rsp_vld_o && rsp_err_o && rsp_data_o == '0));
    a_r4_no_fwd: assert property (@(posedge clk) disable iff (!rst_n)
        dis_i |-> !fwd_vld_o);
endmodule

// File: rtl/fad_phy_gate.sv
// Gate on the physical flash interface.
// Tracks the single outstanding transaction. On disable, a running program
// or erase finishes, a running read is abandoned with an error, and new
// requests are dropped without a response. Assumes requests arrive only
// while idle.
module fad_phy_gate
    import fad_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           dis_i,
    input  logic           req_vld_i,
    input  logic [OPW-1:0] req_op_i,
    input  logic [AW-1:0]  req_addr_i,
    output logic           fwd_vld_o,
    output logic [OPW-1:0] fwd_op_o,
    output logic [AW-1:0]  fwd_addr_o,
    input  logic           done_i,
    input  logic [DW-1:0]  rdata_i,
    output logic           rsp_vld_o,
    output logic           rsp_err_o,
    output logic [DW-1:0]  rsp_data_o
);
    logic           busy_q;
    logic [OPW-1:0] busy_op_q;
    logic           rd_abort;
    logic           pass_done;

    // issue only while enabled and idle
    always_comb begin
        fwd_vld_o  = req_vld_i & ~dis_i & ~busy_q;
        fwd_op_o   = req_op_i;
        fwd_addr_o = req_addr_i;
    end

    // abandon a read in flight; let stateful operations report completion
    always_comb begin
        rd_abort  = dis_i & busy_q & (busy_op_q == OP_READ);
        pass_done = busy_q & done_i & ~rd_abort;
    end

    // response toward the requester
    always_comb begin
        rsp_vld_o  = rd_abort | pass_done;
        rsp_err_o  = rd_abort;
        rsp_data_o = rd_abort ? '0 : rdata_i;
    end

    // outstanding transaction tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q    <= 1'b0;
            busy_op_q <= OP_READ;
        end else if (fwd_vld_o) begin
            busy_q    <= 1'b1;
            busy_op_q <= req_op_i;
        end else if (rd_abort || pass_done) begin
            busy_q    <= 1'b0;
        end
    end

    a_r8_drop: assert property (@(posedge clk) disable iff (!rst_n)
        dis_i |-> !fwd_vld_o);
    a_r7_single: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> !fwd_vld_o);
    a_r9_finish: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_i && busy_q && busy_op_q != OP_READ && done_i) |-> (rsp_vld_o && !rsp_err_o));
    a_r10_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_i && busy_q && busy_op_q == OP_READ) |=> !busy_q);
endmodule

// File: rtl/flash_access_gate.sv
// Top of the flash access disable gate.
// Combines four disable causes into a sticky state and applies it to the
// host, controller and physical paths. Synchronous active-low reset.
module flash_access_gate
    import fad_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           esc_global_i,
    input  logic           esc_local_i,
    input  logic           rma_done_i,
    input  logic           sw_disable_i,
    output logic [NSRC-1:0] dis_src_o,
    output logic           disabled_o,
    input  logic           host_req_i,
    input  logic [AW-1:0]  host_addr_i,
    output logic           host_fwd_req_o,
    output logic [AW-1:0]  host_fwd_addr_o,
    input  logic           host_fwd_rsp_i,
    input  logic [DW-1:0]  host_fwd_rdata_i,
    output logic           host_rsp_o,
    output logic           host_rsp_err_o,
    output logic [DW-1:0]  host_rdata_o,
    input  logic           ctrl_req_i,
    input  logic [OPW-1:0] ctrl_op_i,
    input  logic [AW-1:0]  ctrl_addr_i,
    output logic           ctrl_fwd_req_o,
    output logic [OPW-1:0] ctrl_fwd_op_o,
    output logic [AW-1:0]  ctrl_fwd_addr_o,
    input  logic           ctrl_fwd_rsp_i,
    input  logic [DW-1:0]  ctrl_fwd_rdata_i,
    output logic           ctrl_rsp_o,
    output logic           ctrl_rsp_err_o,
    output logic [DW-1:0]  ctrl_rdata_o,
    input  logic           phy_req_i,
    input  logic [OPW-1:0] phy_op_i,
    input  logic [AW-1:0]  phy_addr_i,
    output logic           phy_fwd_req_o,
    output logic [OPW-1:0] phy_fwd_op_o,
    output logic [AW-1:0]  phy_fwd_addr_o,
    input  logic           phy_done_i,
    input  logic [DW-1:0]  phy_rdata_i,
    output logic           phy_rsp_o,
    output logic           phy_rsp_err_o,
    output logic [DW-1:0]  phy_rdata_o
);
    localparam int CPW = OPW + AW;

    logic [NSRC-1:0] src;
    logic            dis;
    logic [CPW-1:0]  ctrl_pld_out;

    // cause vector in status-bit order
    always_comb begin
        src           = '0;
        src[SRC_GLB]  = esc_global_i;
        src[SRC_LOC]  = esc_local_i;
        src[SRC_WIPE] = rma_done_i;
        src[SRC_SW]   = sw_disable_i;
    end

    fad_src_latch #(.N(NSRC)) u_src (
        .clk(clk), .rst_n(rst_n), .src_i(src), .seen_o(dis_src_o), .dis_o(dis)
    );

    assign disabled_o = dis;

    fad_req_gate #(.PW(AW), .DW(DW)) u_host (
        .clk(clk), .rst_n(rst_n), .dis_i(dis),
        .req_vld_i(host_req_i), .req_pld_i(host_addr_i),
        .fwd_vld_o(host_fwd_req_o), .fwd_pld_o(host_fwd_addr_o),
        .fwd_rsp_vld_i(host_fwd_rsp_i), .fwd_rsp_data_i(host_fwd_rdata_i),
        .rsp_vld_o(host_rsp_o), .rsp_err_o(host_rsp_err_o), .rsp_data_o(host_rdata_o)
    );

    fad_req_gate #(.PW(CPW), .DW(DW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .dis_i(dis),
        .req_vld_i(ctrl_req_i), .req_pld_i({ctrl_op_i, ctrl_addr_i}),
        .fwd_vld_o(ctrl_fwd_req_o), .fwd_pld_o(ctrl_pld_out),
        .fwd_rsp_vld_i(ctrl_fwd_rsp_i), .fwd_rsp_data_i(ctrl_fwd_rdata_i),
        .rsp_vld_o(ctrl_rsp_o), .rsp_err_o(ctrl_rsp_err_o), .rsp_data_o(ctrl_rdata_o)
    );

    // split the forwarded controller payload back into its fields
    assign ctrl_fwd_op_o   = ctrl_pld_out[CPW-1:AW];
    assign ctrl_fwd_addr_o = ctrl_pld_out[AW-1:0];

    fad_phy_gate #(.AW(AW), .DW(DW)) u_phy (
        .clk(clk), .rst_n(rst_n), .dis_i(dis),
        .req_vld_i(phy_req_i), .req_op_i(phy_op_i), .req_addr_i(phy_addr_i),
        .fwd_vld_o(phy_fwd_req_o), .fwd_op_o(phy_fwd_op_o), .fwd_addr_o(phy_fwd_addr_o),
        .done_i(phy_done_i), .rdata_i(phy_rdata_i),
        .rsp_vld_o(phy_rsp_o), .rsp_err_o(phy_rsp_err_o), .rsp_data_o(phy_rdata_o)
    );

    // R11: nothing leaves the block in the cycle after a reset cycle
    a_r11_quiet: assert property (@(posedge clk)
        !rst_n |=> (dis_src_o == '0 && !host_rsp_err_o && !ctrl_rsp_err_o));
endmodule

// File: tb/sim_flash_access_gate.sv
`timescale 1ns/1ps
module sim_flash_access_gate;
    localparam int AW = 16;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic esc_g, esc_l, wipe, swd;
    logic [3:0] dis_src;
    logic disabled;
    logic h_req, h_frsp, h_fwd, h_rsp, h_err;
    logic [AW-1:0] h_addr, h_faddr;
    logic [DW-1:0] h_frd, h_rd;
    logic c_req, c_frsp, c_fwd, c_rsp, c_err;
    logic [1:0] c_op, c_fop;
    logic [AW-1:0] c_addr, c_faddr;
    logic [DW-1:0] c_frd, c_rd;
    logic p_req, p_done, p_fwd, p_rsp, p_err;
    logic [1:0] p_op, p_fop;
    logic [AW-1:0] p_addr, p_faddr;
    logic [DW-1:0] p_rdi, p_rd;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    // reference model state
    logic [3:0] m_src;
    bit m_herr, m_cerr, m_busy;
    logic [1:0] m_op;

    always #2.5 clk = ~clk;

    flash_access_gate #(.AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .esc_global_i(esc_g), .esc_local_i(esc_l), .rma_done_i(wipe), .sw_disable_i(swd),
        .dis_src_o(dis_src), .disabled_o(disabled),
        .host_req_i(h_req), .host_addr_i(h_addr), .host_fwd_req_o(h_fwd), .host_fwd_addr_o(h_faddr),
        .host_fwd_rsp_i(h_frsp), .host_fwd_rdata_i(h_frd),
        .host_rsp_o(h_rsp), .host_rsp_err_o(h_err), .host_rdata_o(h_rd),
        .ctrl_req_i(c_req), .ctrl_op_i(c_op), .ctrl_addr_i(c_addr),
        .ctrl_fwd_req_o(c_fwd), .ctrl_fwd_op_o(c_fop), .ctrl_fwd_addr_o(c_faddr),
        .ctrl_fwd_rsp_i(c_frsp), .ctrl_fwd_rdata_i(c_frd),
        .ctrl_rsp_o(c_rsp), .ctrl_rsp_err_o(c_err), .ctrl_rdata_o(c_rd),
        .phy_req_i(p_req), .phy_op_i(p_op), .phy_addr_i(p_addr),
        .phy_fwd_req_o(p_fwd), .phy_fwd_op_o(p_fop), .phy_fwd_addr_o(p_faddr),
        .phy_done_i(p_done), .phy_rdata_i(p_rdi),
        .phy_rsp_o(p_rsp), .phy_rsp_err_o(p_err), .phy_rdata_o(p_rd)
    );

    task automatic idle();
        {esc_g, esc_l, wipe, swd} = '0;
        h_req = 0; h_addr = '0; h_frsp = 0; h_frd = '0;
        c_req = 0; c_op = '0; c_addr = '0; c_frsp = 0; c_frd = '0;
        p_req = 0; p_op = '0; p_addr = '0; p_done = 0; p_rdi = '0;
    endtask

    // one cycle: inputs are already set just after a falling edge
    task automatic cyc(input string tag);
        logic [3:0] src_now;
        bit dis, abort, ok;
        bit e_hfwd, e_hrsp, e_herr, e_cfwd, e_crsp, e_cerr, e_pfwd, e_prsp, e_perr;
        logic [DW-1:0] e_hrd, e_crd, e_prd;
        #1;
        dis    = (m_src != 0);
        e_hfwd = h_req && !dis;
        e_hrsp = m_herr || h_frsp;  e_herr = m_herr;  e_hrd = m_herr ? '0 : h_frd;
        e_cfwd = c_req && !dis;
        e_crsp = m_cerr || c_frsp;  e_cerr = m_cerr;  e_crd = m_cerr ? '0 : c_frd;
        e_pfwd = p_req && !dis && !m_busy;
        abort  = dis && m_busy && (m_op == 2'd0);
        e_prsp = abort || (m_busy && p_done);
        e_perr = abort;
        e_prd  = abort ? '0 : p_rdi;
        ok = (dis_src === m_src) && (disabled === dis)
          && (h_fwd === e_hfwd) && (h_faddr === h_addr) && (h_rsp === e_hrsp)
          && (h_err === e_herr) && (h_rd === e_hrd)
          && (c_fwd === e_cfwd) && (c_fop === c_op) && (c_faddr === c_addr)
          && (c_rsp === e_crsp) && (c_err === e_cerr) && (c_rd === e_crd)
          && (p_fwd === e_pfwd) && (p_fop === p_op) && (p_faddr === p_addr)
          && (p_rsp === e_prsp) && (p_err === e_perr) && (p_rd === e_prd);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: act src=%b dis=%b h=%b%b%b/%h c=%b%b%b/%h p=%b%b%b/%h exp src=%b dis=%b h=%b%b%b/%h c=%b%b%b/%h p=%b%b%b/%h",
                tag, dis_src, disabled, h_fwd, h_rsp, h_err, h_rd, c_fwd, c_rsp, c_err, c_rd,
                p_fwd, p_rsp, p_err, p_rd,
                m_src, dis, e_hfwd, e_hrsp, e_herr, e_hrd, e_cfwd, e_crsp, e_cerr, e_crd,
                e_pfwd, e_prsp, e_perr, e_prd);
        end
        src_now = {swd, wipe, esc_l, esc_g};
        @(posedge clk);
        if (!rst_n) begin
            m_src = '0; m_herr = 0; m_cerr = 0; m_busy = 0; m_op = '0;
        end else begin
            m_herr = dis && h_req;
            m_cerr = dis && c_req;
            if (e_pfwd) begin
                m_busy = 1; m_op = p_op;
            end else if (m_busy && (p_done || abort)) begin
                m_busy = 0;
            end
            m_src = m_src | src_now;
        end
        @(negedge clk);
    endtask

    task automatic do_reset();
        idle();
        rst_n = 0;
        cyc("R11"); cyc("R11");
        rst_n = 1;
        cyc("R11");
    endtask

    initial begin
        m_src = '0; m_herr = 0; m_cerr = 0; m_busy = 0; m_op = '0;
        idle();
        @(negedge clk);
        do_reset();

        // R3 host pass-through
        h_req = 1; h_addr = 16'h1234; cyc("R3");
        h_req = 0; h_frsp = 1; h_frd = 32'hCAFE0001; cyc("R3");
        idle(); cyc("R3");
        // R5 controller pass-through
        c_req = 1; c_op = 2'd1; c_addr = 16'h0420; cyc("R5");
        idle(); c_frsp = 1; c_frd = 32'h5A5A0002; cyc("R5");
        idle(); cyc("R5");
        // R7 physical read then erase
        p_req = 1; p_op = 2'd0; p_addr = 16'h0010; cyc("R7");
        idle(); cyc("R7");
        p_done = 1; p_rdi = 32'h0BADF00D; cyc("R7");
        idle(); p_req = 1; p_op = 2'd2; p_addr = 16'h0200; cyc("R7");
        idle(); p_done = 1; p_rdi = 32'h11112222; cyc("R7");
        idle(); cyc("R7");

        // R9 program in flight, software disable (R1 bit 3)
        p_req = 1; p_op = 2'd1; p_addr = 16'h0300; cyc("R9");
        idle(); h_req = 1; h_addr = 16'h0777; swd = 1; cyc("R1");
        idle(); cyc("R1");
        cyc("R9");
        p_done = 1; p_rdi = 32'h00C0FFEE; cyc("R9");
        idle(); cyc("R9");
        // R4 host refused, back-to-back
        h_req = 1; h_addr = 16'h0001; cyc("R4");
        h_addr = 16'h0002; cyc("R4");
        h_req = 0; cyc("R4");
        cyc("R4");
        // R6 controller refused
        c_req = 1; c_op = 2'd2; c_addr = 16'h0ABC; cyc("R6");
        idle(); cyc("R6");
        cyc("R6");
        // R8 physical dropped, stray completion ignored
        p_req = 1; p_op = 2'd0; p_addr = 16'h0044; cyc("R8");
        p_op = 2'd1; cyc("R8");
        idle(); p_done = 1; p_rdi = 32'h12345678; cyc("R8");
        idle(); cyc("R8");
        // R2 sticky after causes drop
        for (int i = 0; i < 4; i++) cyc("R2");

        // R10 read in flight, wipe completion cause (R1 bit 2)
        do_reset();
        p_req = 1; p_op = 2'd0; p_addr = 16'h0055; cyc("R10");
        idle(); wipe = 1; cyc("R1");
        idle(); cyc("R10");
        cyc("R10");
        p_done = 1; p_rdi = 32'hDEADBEEF; cyc("R10");
        idle(); cyc("R10");

        // R1 global escalation alone
        do_reset();
        esc_g = 1; cyc("R1");
        idle(); cyc("R1");
        h_req = 1; h_addr = 16'h0099; cyc("R4");
        idle(); cyc("R4");

        // R9 erase in flight, local escalation (R1 bit 1)
        do_reset();
        p_req = 1; p_op = 2'd2; p_addr = 16'h0600; cyc("R9");
        idle(); esc_l = 1; cyc("R1");
        idle(); cyc("R9");
        p_done = 1; p_rdi = 32'h00000777; cyc("R9");
        idle(); cyc("R9");
        c_req = 1; c_op = 2'd0; cyc("R6");
        idle(); cyc("R6");

        // R2 reset is the only clear
        do_reset();
        cyc("R2");

        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1;
            tests++; fails++;
            $display("FAIL watchdog: act hung exp finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule